// File: doc/BRIEF.md
# Secure Session Access State Machine

This block keeps the security posture of one host session for a protected memory. It holds the session mode (plain, authenticated or encrypted), the single credential that the host has most recently proven, and a run of consecutive failed attempts. An external comparator does the cryptography and reports each outcome as a one-cycle strobe: password accepted or rejected, authentication accepted or rejected. The host may also request the encrypted mode, and the integrity checker may flag a bad message code.

For each access, the caller presents the protection word of the target zone on the `cfg_*` inputs. The word holds a password index, a key index, a password-required bit, an authentication-required bit and an encryption-required bit. The block answers combinationally with a read grant and a write grant. After four failures in a row it raises a lockout flag and stops acting on new verification results until reset.

Top module: `ssa_session`

## Requirements
- R1: While `rst_ni` is low and after its release, `mode_o` is 2'b00 (plain), no password is held, the failure count is zero and `lockout_o` is 0; with every `cfg_*_req_i` bit low both grants are 1.
- R2: An accepted authentication pass sets `mode_o` to 2'b01 (authenticated) on the next cycle and stores `key_sel_i` as the session key, including from encrypted mode. An accepted authentication fail sets the mode to 2'b00. When pass and fail come in the same cycle, the fail wins.
- R3: `enc_req_i` moves the mode from 2'b01 to 2'b10 (encrypted) on the next cycle. In plain mode it has no effect.
- R4: `mac_bad_i` returns an authenticated or encrypted session to 2'b00 on the next cycle, taking priority over `enc_req_i`. An accepted authentication result in the same cycle takes priority over `mac_bad_i`.
- R5: An accepted password pass replaces the held password with `pw_sel_i` and its kind `pw_is_wr_i` (1 = write password). An accepted password fail clears the held password. A fail outranks a pass in the same cycle.
- R6: A held write password with a matching index grants both read and write. A held read password with a matching index grants read only.
- R7: Each cycle with at least one accepted fail strobe adds one to the failure count, which saturates at 4. A cycle with an accepted pass and no fail clears the count. `lockout_o` is 1 exactly when the count is 4.
- R8: While `lockout_o` is 1, the four result strobes change no state. `enc_req_i` and `mac_bad_i` still act.
- R9: A grant is given only when every requirement in the zone word is met. A set `cfg_pw_req_i` needs a held password whose index equals `cfg_pw_sel_i`. A set `cfg_auth_req_i` needs mode 2'b01 or 2'b10 with the session key equal to `cfg_key_sel_i`. A set `cfg_enc_req_i` needs mode 2'b10 with that same key match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pw_ok_i | input | 1 | Password verify passed (pulse) |
| pw_bad_i | input | 1 | Password verify failed (pulse) |
| pw_sel_i | input | 3 | Index of the presented password set |
| pw_is_wr_i | input | 1 | Presented password is a write password |
| auth_ok_i | input | 1 | Authentication passed (pulse) |
| auth_bad_i | input | 1 | Authentication failed (pulse) |
| key_sel_i | input | 2 | Key set used in the authentication |
| enc_req_i | input | 1 | Request to enter encrypted mode (pulse) |
| mac_bad_i | input | 1 | Message code mismatch (pulse) |
| cfg_pw_sel_i | input | 3 | Zone word: required password index |
| cfg_key_sel_i | input | 2 | Zone word: required key index |
| cfg_pw_req_i | input | 1 | Zone word: password required |
| cfg_auth_req_i | input | 1 | Zone word: authentication required |
| cfg_enc_req_i | input | 1 | Zone word: encryption required |
| mode_o | output | 2 | Session mode: 00 plain, 01 authenticated, 10 encrypted |
| rd_grant_o | output | 1 | Read access granted for the zone word |
| wr_grant_o | output | 1 | Write access granted for the zone word |
| lockout_o | output | 1 | Four consecutive failures seen |

## Verification
The mode register can receive several events in the same cycle. An authentication result, a message-code mismatch and an encryption request may all arrive together, and a password result may land in the same cycle as an authentication result, so the failure counter sees both. The random stimulus raises each strobe on its own, which makes these collisions frequent. Directed cases force the mismatch together with an encryption request, and the mismatch together with an authentication pass. A per-cycle reference model applies the stated priority order, and each output is compared with it one cycle after the strobes.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_AUTH  = 2'b01,
    MODE_ENC   = 2'b10
  } sess_mode_e;
endpackage

// File: rtl/ssa_fail_ctr.sv
module ssa_fail_ctr #(
  parameter int MAX_FAIL = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic pass_i,
  output logic lockout_o
);
  localparam int CNT_W = $clog2(MAX_FAIL + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_FAIL);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = fail_i | pass_i;

  always_comb begin
    cnt_d = cnt_q;
    if (fail_i) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end else if (pass_i) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign lockout_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/ssa_mode_fsm.sv
module ssa_mode_fsm
  import ssa_pkg::*;
#(
  parameter int KEY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auth_ok_i,
  input  logic             auth_bad_i,
  input  logic [KEY_W-1:0] key_sel_i,
  input  logic             enc_req_i,
  input  logic             mac_bad_i,
  output sess_mode_e       mode_o,
  output logic [KEY_W-1:0] key_o
);
  sess_mode_e       mode_q, mode_d;
  logic [KEY_W-1:0] key_q;
  logic             key_en;

  assign key_en = auth_ok_i & ~auth_bad_i;

  always_comb begin
    mode_d = mode_q;
    if (auth_bad_i)                             mode_d = MODE_PLAIN;
    else if (auth_ok_i)                         mode_d = MODE_AUTH;
    else if (mac_bad_i)                         mode_d = MODE_PLAIN;
    else if (enc_req_i && mode_q == MODE_AUTH)  mode_d = MODE_ENC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_PLAIN;
    else         mode_q <= mode_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     key_q <= '0;
    else if (key_en) key_q <= key_sel_i;
  end

  assign mode_o = mode_q;
  assign key_o  = key_q;
endmodule

// File: rtl/ssa_cred.sv
module ssa_cred #(
  parameter int PW_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pw_ok_i,
  input  logic            pw_bad_i,
  input  logic [PW_W-1:0] pw_sel_i,
  input  logic            pw_is_wr_i,
  output logic            held_o,
  output logic [PW_W-1:0] idx_o,
  output logic            is_wr_o
);
  logic            held_q, held_d;
  logic [PW_W-1:0] idx_q;
  logic            wr_q;
  logic            load_en;

  assign load_en = pw_ok_i & ~pw_bad_i;

  always_comb begin
    held_d = held_q;
    if (pw_bad_i)     held_d = 1'b0;
    else if (pw_ok_i) held_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else         held_q <= held_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      wr_q  <= 1'b0;
    end else if (load_en) begin
      idx_q <= pw_sel_i;
      wr_q  <= pw_is_wr_i;
    end
  end

  assign held_o  = held_q;
  assign idx_o   = idx_q;
  assign is_wr_o = wr_q;
endmodule

// File: rtl/ssa_grant.sv
module ssa_grant
  import ssa_pkg::*;
#(
  parameter int PW_W  = 3,
  parameter int KEY_W = 2
) (
  input  sess_mode_e       mode_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             held_i,
  input  logic [PW_W-1:0]  idx_i,
  input  logic             is_wr_i,
  input  logic [PW_W-1:0]  cfg_pw_sel_i,
  input  logic [KEY_W-1:0] cfg_key_sel_i,
  input  logic             cfg_pw_req_i,
  input  logic             cfg_auth_req_i,
  input  logic             cfg_enc_req_i,
  output logic             rd_o,
  output logic             wr_o
);
  logic pw_match, key_match, pw_rd_ok, pw_wr_ok, auth_ok, enc_ok;

  always_comb begin
    pw_match  = held_i && (idx_i == cfg_pw_sel_i);
    key_match = (key_i == cfg_key_sel_i);
    pw_rd_ok  = ~cfg_pw_req_i | pw_match;
    pw_wr_ok  = ~cfg_pw_req_i | (pw_match & is_wr_i);
    auth_ok   = ~cfg_auth_req_i | ((mode_i != MODE_PLAIN) & key_match);
    enc_ok    = ~cfg_enc_req_i  | ((mode_i == MODE_ENC) & key_match);
    rd_o      = pw_rd_ok & auth_ok & enc_ok;
    wr_o      = pw_wr_ok & auth_ok & enc_ok;
  end
endmodule

// File: rtl/ssa_session.sv
module ssa_session
  import ssa_pkg::*;
#(
  parameter int NUM_PW   = 8,
  parameter int NUM_KEY  = 4,
  parameter int MAX_FAIL = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pw_ok_i,
  input  logic                       pw_bad_i,
  input  logic [$clog2(NUM_PW)-1:0]  pw_sel_i,
  input  logic                       pw_is_wr_i,
  input  logic                       auth_ok_i,
  input  logic                       auth_bad_i,
  input  logic [$clog2(NUM_KEY)-1:0] key_sel_i,
  input  logic                       enc_req_i,
  input  logic                       mac_bad_i,
  input  logic [$clog2(NUM_PW)-1:0]  cfg_pw_sel_i,
  input  logic [$clog2(NUM_KEY)-1:0] cfg_key_sel_i,
  input  logic                       cfg_pw_req_i,
  input  logic                       cfg_auth_req_i,
  input  logic                       cfg_enc_req_i,
  output logic [1:0]                 mode_o,
  output logic                       rd_grant_o,
  output logic                       wr_grant_o,
  output logic                       lockout_o
);
  localparam int PW_W  = $clog2(NUM_PW);
  localparam int KEY_W = $clog2(NUM_KEY);

  logic             locked;
  logic             acc_pw_ok, acc_pw_bad, acc_auth_ok, acc_auth_bad;
  sess_mode_e       mode;
  logic [KEY_W-1:0] sess_key;
  logic             held, held_wr;
  logic [PW_W-1:0]  held_idx;

  // Verification results only count while not locked out
  assign acc_pw_ok    = pw_ok_i    & ~locked;
  assign acc_pw_bad   = pw_bad_i   & ~locked;
  assign acc_auth_ok  = auth_ok_i  & ~locked;
  assign acc_auth_bad = auth_bad_i & ~locked;

  ssa_fail_ctr #(.MAX_FAIL(MAX_FAIL)) u_fail (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fail_i    (acc_pw_bad | acc_auth_bad),
    .pass_i    (acc_pw_ok | acc_auth_ok),
    .lockout_o (locked)
  );

  ssa_mode_fsm #(.KEY_W(KEY_W)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .auth_ok_i  (acc_auth_ok),
    .auth_bad_i (acc_auth_bad),
    .key_sel_i  (key_sel_i),
    .enc_req_i  (enc_req_i),
    .mac_bad_i  (mac_bad_i),
    .mode_o     (mode),
    .key_o      (sess_key)
  );

  ssa_cred #(.PW_W(PW_W)) u_cred (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pw_ok_i    (acc_pw_ok),
    .pw_bad_i   (acc_pw_bad),
    .pw_sel_i   (pw_sel_i),
    .pw_is_wr_i (pw_is_wr_i),
    .held_o     (held),
    .idx_o      (held_idx),
    .is_wr_o    (held_wr)
  );

  ssa_grant #(.PW_W(PW_W), .KEY_W(KEY_W)) u_grant (
    .mode_i         (mode),
    .key_i          (sess_key),
    .held_i         (held),
    .idx_i          (held_idx),
    .is_wr_i        (held_wr),
    .cfg_pw_sel_i   (cfg_pw_sel_i),
    .cfg_key_sel_i  (cfg_key_sel_i),
    .cfg_pw_req_i   (cfg_pw_req_i),
    .cfg_auth_req_i (cfg_auth_req_i),
    .cfg_enc_req_i  (cfg_enc_req_i),
    .rd_o           (rd_grant_o),
    .wr_o           (wr_grant_o)
  );

  assign mode_o    = mode;
  assign lockout_o = locked;
endmodule

// File: rtl/ssa_session_chk.sv
module ssa_session_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       auth_ok_i,
  input logic       auth_bad_i,
  input logic       enc_req_i,
  input logic       mac_bad_i,
  input logic       cfg_enc_req_i,
  input logic [1:0] mode_o,
  input logic       rd_grant_o,
  input logic       wr_grant_o,
  input logic       lockout_o
);
  AST_ENC_ONLY_FROM_AUTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10 && $past(mode_o) != 2'b10) |-> ($past(mode_o) == 2'b01 && $past(enc_req_i))); // R3

  AST_MAC_DROPS_SESSION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mac_bad_i && !(auth_ok_i && !lockout_o)) |=> (mode_o == 2'b00)); // R4

  AST_AUTH_FAIL_REVOKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auth_bad_i && !lockout_o) |=> (mode_o == 2'b00)); // R2

  AST_LOCKOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o |=> lockout_o); // R8

  AST_WRITE_IMPLIES_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_grant_o |-> rd_grant_o); // R6

  AST_ENC_ZONE_NEEDS_ENC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_enc_req_i && mode_o != 2'b10) |-> !rd_grant_o); // R9

  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11); // R2
endmodule

bind ssa_session ssa_session_chk u_ssa_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .auth_ok_i     (auth_ok_i),
  .auth_bad_i    (auth_bad_i),
  .enc_req_i     (enc_req_i),
  .mac_bad_i     (mac_bad_i),
  .cfg_enc_req_i (cfg_enc_req_i),
  .mode_o        (mode_o),
  .rd_grant_o    (rd_grant_o),
  .wr_grant_o    (wr_grant_o),
  .lockout_o     (lockout_o)
);

// File: tb/ssa_session_bench.sv
module ssa_session_bench;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       pw_ok, pw_bad, pw_is_wr, auth_ok, auth_bad, enc_req, mac_bad;
  logic [2:0] pw_sel, cfg_pw_sel;
  logic [1:0] key_sel, cfg_key_sel;
  logic       cfg_pw_req, cfg_auth_req, cfg_enc_req;
  logic [1:0] mode;
  logic       rd_grant, wr_grant, lockout;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model state
  int         m_mode, m_cnt;
  logic [1:0] m_key;
  bit         m_held, m_wr;
  logic [2:0] m_idx;

  always #4 clk = ~clk;

  ssa_session u_ssa_session (
    .clk_i(clk), .rst_ni(rst_ni),
    .pw_ok_i(pw_ok), .pw_bad_i(pw_bad), .pw_sel_i(pw_sel), .pw_is_wr_i(pw_is_wr),
    .auth_ok_i(auth_ok), .auth_bad_i(auth_bad), .key_sel_i(key_sel),
    .enc_req_i(enc_req), .mac_bad_i(mac_bad),
    .cfg_pw_sel_i(cfg_pw_sel), .cfg_key_sel_i(cfg_key_sel),
    .cfg_pw_req_i(cfg_pw_req), .cfg_auth_req_i(cfg_auth_req), .cfg_enc_req_i(cfg_enc_req),
    .mode_o(mode), .rd_grant_o(rd_grant), .wr_grant_o(wr_grant), .lockout_o(lockout)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit f_rd();
    bit pm = m_held && (m_idx == cfg_pw_sel);
    bit km = (m_key == cfg_key_sel);
    return (!cfg_pw_req || pm) && (!cfg_auth_req || (m_mode != 0 && km))
           && (!cfg_enc_req || (m_mode == 2 && km));
  endfunction

  function automatic bit f_wr();
    bit pm = m_held && (m_idx == cfg_pw_sel) && m_wr;
    bit km = (m_key == cfg_key_sel);
    return (!cfg_pw_req || pm) && (!cfg_auth_req || (m_mode != 0 && km))
           && (!cfg_enc_req || (m_mode == 2 && km));
  endfunction

  task automatic idle();
    {pw_ok, pw_bad, auth_ok, auth_bad, enc_req, mac_bad} = '0;
  endtask

  task automatic model_reset();
    m_mode = 0; m_cnt = 0; m_key = '0; m_held = 0; m_wr = 0; m_idx = '0;
  endtask

  // apply current strobes to model, advance one clock, compare at negedge
  task automatic step();
    bit acc = (m_cnt != 4);
    bit apass = acc && auth_ok, afail = acc && auth_bad;
    bit ppass = acc && pw_ok,   pfail = acc && pw_bad;
    if (afail || pfail) begin
      if (m_cnt < 4) m_cnt++;
    end else if (apass || ppass) m_cnt = 0;
    if (afail) m_mode = 0;
    else if (apass) begin m_mode = 1; m_key = key_sel; end
    else if (mac_bad) m_mode = 0;
    else if (enc_req && m_mode == 1) m_mode = 2;
    if (pfail) m_held = 0;
    else if (ppass) begin m_held = 1; m_idx = pw_sel; m_wr = pw_is_wr; end
    @(posedge clk);
    @(negedge clk);
    idle();
    chk("R2 mode", mode, m_mode);
    chk("R7 lockout", lockout, (m_cnt == 4));
    chk("R9 rd_grant", rd_grant, f_rd());
    chk("R6 wr_grant", wr_grant, f_wr());
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
  endtask

  task automatic set_cfg(input logic [2:0] p, input logic [1:0] k,
                         input bit pr, input bit ar, input bit er);
    cfg_pw_sel = p; cfg_key_sel = k;
    cfg_pw_req = pr; cfg_auth_req = ar; cfg_enc_req = er;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    pw_sel = '0; pw_is_wr = 0; key_sel = '0;
    set_cfg(3'd0, 2'd0, 0, 0, 0);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 mode in reset", mode, 0);
    chk("R1 lockout in reset", lockout, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
    @(negedge clk);
    chk("R1 rd with no requirements", rd_grant, 1);
    chk("R1 wr with no requirements", wr_grant, 1);
    set_cfg(3'd0, 2'd0, 1, 0, 0);
    #1;
    chk("R1 no password held", rd_grant, 0);

    // R5 / R6: password kinds and replacement
    set_cfg(3'd5, 2'd0, 1, 0, 0);
    pw_ok = 1; pw_sel = 3'd5; pw_is_wr = 0; step();
    chk("R6 read pw gives read", rd_grant, 1);
    chk("R6 read pw denies write", wr_grant, 0);
    pw_ok = 1; pw_sel = 3'd5; pw_is_wr = 1; step();
    chk("R6 write pw gives read", rd_grant, 1);
    chk("R6 write pw gives write", wr_grant, 1);
    pw_ok = 1; pw_sel = 3'd3; pw_is_wr = 1; step();
    chk("R5 new pw replaces old", rd_grant, 0);
    set_cfg(3'd3, 2'd0, 1, 0, 0);
    pw_ok = 1; pw_bad = 1; step();
    chk("R5 fail beats pass", rd_grant, 0);

    // R2 / R3 / R4 / R9: mode path
    set_cfg(3'd0, 2'd2, 0, 0, 1);
    enc_req = 1; step();
    chk("R3 enc ignored in plain", mode, 0);
    auth_ok = 1; key_sel = 2'd2; step();
    chk("R2 auth pass", mode, 1);
    enc_req = 1; step();
    chk("R3 enc from auth", mode, 2);
    chk("R9 enc zone matching key", rd_grant, 1);
    set_cfg(3'd0, 2'd1, 0, 0, 1);
    #1;
    chk("R9 enc zone wrong key", rd_grant, 0);
    enc_req = 1; mac_bad = 1; step();
    chk("R4 mac beats enc", mode, 0);
    auth_ok = 1; mac_bad = 1; key_sel = 2'd1; step();
    chk("R4 auth beats mac", mode, 1);
    auth_bad = 1; step();
    chk("R2 auth fail revokes", mode, 0);

    // R7 / R8: lockout
    do_reset();
    repeat (3) begin pw_bad = 1; step(); end
    chk("R7 three fails not locked", lockout, 0);
    auth_bad = 1; pw_bad = 1; step();
    chk("R7 fourth fail locks", lockout, 1);
    set_cfg(3'd4, 2'd0, 1, 0, 0);
    pw_ok = 1; pw_sel = 3'd4; auth_ok = 1; step();
    chk("R8 pw ignored when locked", rd_grant, 0);
    chk("R8 auth ignored when locked", mode, 0);
    chk("R8 lockout held", lockout, 1);
    do_reset();
    @(negedge clk);
    chk("R1 reset clears lockout", lockout, 0);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      if (i % 500 == 499) do_reset();
      pw_ok    = ($urandom_range(0, 4) == 0);
      pw_bad   = ($urandom_range(0, 7) == 0);
      pw_sel   = 3'($urandom_range(0, 7));
      pw_is_wr = 1'($urandom_range(0, 1));
      auth_ok  = ($urandom_range(0, 5) == 0);
      auth_bad = ($urandom_range(0, 9) == 0);
      key_sel  = 2'($urandom_range(0, 3));
      enc_req  = ($urandom_range(0, 3) == 0);
      mac_bad  = ($urandom_range(0, 7) == 0);
      set_cfg(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              ($urandom_range(0, 3) == 0));
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule